// File: doc/BRIEF.md
# Cartridge Bank Switching Address Translator

This block sits between a console's CPU and video buses and the ROMs on a cartridge. The CPU programs it by writing into the top half of its address space. Those writes land in a select register, eight bank-number registers and a single mirroring flag. From that state the block turns a 15-bit CPU program address into a physical program ROM address, and a 13-bit video pattern address into a physical character memory address. It also folds the video nametable address into an 11-bit index for the console's 2 KB internal video RAM.

Program space is split into four 8 KB windows. Two bank registers and two fixed banks at the top of the ROM fill them, and one select bit chooses which fixed bank sits at the bottom. Character space is split into eight 1 KB windows. Two registers each cover a 2 KB pair of windows and four registers each cover a single window. A second select bit swaps the lower and upper 4 KB halves. A parameter of zero character banks turns the character path into a straight pass-through to character RAM.

Translation is combinational from the register state. A register write changes the mapping from the cycle after its clock edge.

Top module: `cart_bank_xlat`

## Requirements
- R1: Synchronous reset clears the select register, all eight bank registers and the mirroring flag to zero. After reset, program window 0 maps to bank 0, window 2 maps to bank PRG_BANKS-2 and window 3 maps to bank PRG_BANKS-1.
- R2: A write is decoded only when wr_addr[15] is 1. In region wr_addr[14:13]=00, an even address (bit 0 = 0) loads the select register. An odd address loads the bank register numbered by select[2:0]. This holds at both ends of the region (0x8000/0x8001 and 0x9FFE/0x9FFF).
- R3: Program window = cpu_addr[14:13] and offset = cpu_addr[12:0], giving prg_rom_addr = {bank, offset}. With select[6]=0, windows 0..3 use register 6, register 7, bank PRG_BANKS-2 and bank PRG_BANKS-1.
- R4: With select[6]=1, windows 0..3 use bank PRG_BANKS-2, register 7, register 6 and bank PRG_BANKS-1.
- R5: Bank counts are powers of two, and every bank number keeps only its low log2(count) bits.
- R6: Character window = vid_addr[12:10] and offset = vid_addr[9:0], giving chr_addr = {bank, offset}. With select[7]=0, windows 0,1 use register 0 with bit 0 forced to 0 and then 1, and windows 2,3 do the same with register 1. Windows 4..7 use registers 2..5.
- R7: With select[7]=1, windows 0..3 use registers 2..5, and windows 4..7 use the register 0 and register 1 pairs as in R6.
- R8: With CHR_BANKS = 0, chr_addr equals vid_addr zero-extended, whatever the register state.
- R9: An even write in region 01 (0xA000–0xBFFF) sets the mirroring flag from wr_data[0]. The following writes change nothing visible: odd writes in region 01, any write in regions 10 and 11, writes with wr_addr[15]=0, and cycles with wr_en low.
- R10: With the mirroring flag 0, vram_addr = vid_addr[10:0]. With the flag 1, vram_addr = {vid_addr[11], vid_addr[9:0]}.
- R11: Outputs follow address inputs in the same cycle. A write takes effect after the clock edge that samples it, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | CPU write strobe, sampled on the rising edge |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data |
| cpu_addr | input | 15 | CPU program address inside the 32 KB program area |
| vid_addr | input | 13 | Video address (pattern space, low bits also used for nametables) |
| prg_rom_addr | output | 13+log2(PRG_BANKS) | Physical program ROM byte address |
| chr_addr | output | max(13, 10+log2(CHR_BANKS)) | Physical character ROM byte address, or RAM address in pass-through |
| vram_addr | output | 11 | Internal video RAM address after mirroring |

## Verification
The main instance uses 16 program banks and 32 character banks. Bank values are written with bits above the mask set, so the truncation of R5 shows in the output and cannot be masked by luck. Sixteen banks place the two fixed windows at 14 and 15, which makes both select bit 6 settings distinguishable in every window. A second instance with 4 program banks and zero character banks drives the same buses and exposes the character pass-through while the first instance is being reprogrammed.

// File: rtl/cbx_pkg.sv
package cbx_pkg;
  localparam int NUM_BANK_REGS = 8;
  localparam int DATA_W        = 8;
  localparam int PRG_OFS_W     = 13;
  localparam int CHR_OFS_W     = 10;
  localparam int VRAM_W        = 11;

  typedef logic [DATA_W-1:0] byte_t;

  typedef enum logic [1:0] {
    WR_IDLE,
    WR_SELECT,
    WR_BANK,
    WR_MIRROR
  } wr_kind_e;

  function automatic int idx_bits(int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

  function automatic int chr_width(int n);
    int w;
    w = CHR_OFS_W + idx_bits(n);
    return (w > 13) ? w : 13;
  endfunction
endpackage

// File: rtl/cbx_regfile.sv
module cbx_regfile
  import cbx_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  logic [15:0]                   wr_addr,
  input  byte_t                         wr_data,
  output byte_t                         sel_q,
  output logic [NUM_BANK_REGS-1:0][7:0] bank_q,
  output logic                          mirror_q
);
  wr_kind_e kind;
  logic     unused_addr;

  assign unused_addr = ^wr_addr[12:1];

  always_comb begin
    kind = WR_IDLE;
    if (wr_en && wr_addr[15]) begin
      unique case (wr_addr[14:13])
        2'b00:   kind = wr_addr[0] ? WR_BANK : WR_SELECT;
        2'b01:   kind = wr_addr[0] ? WR_IDLE : WR_MIRROR;
        default: kind = WR_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q    <= '0;
      bank_q   <= '0;
      mirror_q <= 1'b0;
    end else begin
      if (kind == WR_SELECT) sel_q <= wr_data;
      if (kind == WR_MIRROR) mirror_q <= wr_data[0];
      for (int i = 0; i < NUM_BANK_REGS; i++) begin
        if (kind == WR_BANK && sel_q[2:0] == i[2:0]) bank_q[i] <= wr_data;
      end
    end
  end
endmodule

// File: rtl/cbx_prg_map.sv
module cbx_prg_map
  import cbx_pkg::*;
#(
  parameter int PRG_BANKS = 16,
  localparam int PRG_BW   = idx_bits(PRG_BANKS),
  localparam int PRG_AW   = PRG_OFS_W + PRG_BW
) (
  input  logic              fixed_low,
  input  byte_t             reg_a,
  input  byte_t             reg_b,
  input  logic [14:0]       cpu_addr,
  output logic [PRG_AW-1:0] prg_addr
);
  localparam byte_t SECOND_LAST = byte_t'(PRG_BANKS - 2);
  localparam byte_t LAST_BANK   = byte_t'(PRG_BANKS - 1);

  byte_t pick;
  logic  unused_prg;

  always_comb begin
    unique case (cpu_addr[14:13])
      2'd0:    pick = fixed_low ? SECOND_LAST : reg_a;
      2'd1:    pick = reg_b;
      2'd2:    pick = fixed_low ? reg_a : SECOND_LAST;
      default: pick = LAST_BANK;
    endcase
  end

  assign unused_prg = ^pick;
  assign prg_addr   = {pick[PRG_BW-1:0], cpu_addr[PRG_OFS_W-1:0]};
endmodule

// File: rtl/cbx_chr_map.sv
module cbx_chr_map
  import cbx_pkg::*;
#(
  parameter int CHR_BANKS = 32,
  localparam int CHR_BW   = idx_bits(CHR_BANKS),
  localparam int MAP_W    = CHR_OFS_W + CHR_BW,
  localparam int CHR_AW   = chr_width(CHR_BANKS)
) (
  input  logic              swap_halves,
  input  logic [5:0][7:0]   regs,
  input  logic [12:0]       vid_addr,
  output logic [CHR_AW-1:0] chr_addr
);
  byte_t            win_bank [8];
  byte_t            cur;
  logic [MAP_W-1:0] mapped;
  logic             unused_chr;

  for (genvar w = 0; w < 8; w++) begin : g_win
    localparam int K    = w % 4;
    localparam bit HIGH = (w >= 4);
    byte_t pair_v, one_v;
    assign pair_v      = {regs[K/2][7:1], (K % 2 == 1)};
    assign one_v       = regs[2+K];
    assign win_bank[w] = (HIGH ^ swap_halves) ? one_v : pair_v;
  end

  assign cur        = win_bank[vid_addr[12:10]];
  assign mapped     = {cur[CHR_BW-1:0], vid_addr[CHR_OFS_W-1:0]};
  assign unused_chr = ^{cur, regs[0][0], regs[1][0]};
  assign chr_addr   = (CHR_BANKS == 0) ? CHR_AW'(vid_addr) : CHR_AW'(mapped);
endmodule

// File: rtl/cart_bank_xlat.sv
module cart_bank_xlat
  import cbx_pkg::*;
#(
  parameter int PRG_BANKS = 16,
  parameter int CHR_BANKS = 32,
  localparam int PRG_AW   = PRG_OFS_W + idx_bits(PRG_BANKS),
  localparam int CHR_AW   = chr_width(CHR_BANKS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [15:0]       wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [14:0]       cpu_addr,
  input  logic [12:0]       vid_addr,
  output logic [PRG_AW-1:0] prg_rom_addr,
  output logic [CHR_AW-1:0] chr_addr,
  output logic [10:0]       vram_addr
);
  byte_t                         sel_q;
  logic [NUM_BANK_REGS-1:0][7:0] bank_q;
  logic                          mirror_q;

  cbx_regfile u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .sel_q    (sel_q),
    .bank_q   (bank_q),
    .mirror_q (mirror_q)
  );

  cbx_prg_map #(.PRG_BANKS(PRG_BANKS)) u_prg (
    .fixed_low (sel_q[6]),
    .reg_a     (bank_q[6]),
    .reg_b     (bank_q[7]),
    .cpu_addr  (cpu_addr),
    .prg_addr  (prg_rom_addr)
  );

  cbx_chr_map #(.CHR_BANKS(CHR_BANKS)) u_chr (
    .swap_halves (sel_q[7]),
    .regs        (bank_q[5:0]),
    .vid_addr    (vid_addr),
    .chr_addr    (chr_addr)
  );

  logic unused_sel;
  assign unused_sel = ^sel_q[5:3];

  assign vram_addr = mirror_q ? {vid_addr[11], vid_addr[9:0]} : vid_addr[VRAM_W-1:0];
endmodule

// File: rtl/cbx_checker.sv
module cbx_checker
  import cbx_pkg::*;
#(
  parameter int PRG_BANKS = 16,
  parameter int CHR_BANKS = 32,
  localparam int PRG_BW   = idx_bits(PRG_BANKS),
  localparam int PRG_AW   = PRG_OFS_W + PRG_BW,
  localparam int CHR_AW   = chr_width(CHR_BANKS)
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              wr_top,
  input logic [14:0]       cpu_addr,
  input logic [12:0]       vid_addr,
  input logic [PRG_AW-1:0] prg_rom_addr,
  input logic [CHR_AW-1:0] chr_addr,
  input logic [10:0]       vram_addr,
  input logic [7:0]        sel_q
);
  localparam logic [PRG_BW-1:0] LAST = PRG_BW'(PRG_BANKS - 1);

  p_reset_sel_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> sel_q == 8'h00);

  p_prg_offset_r3: assert property (@(posedge clk) disable iff (rst)
    prg_rom_addr[12:0] == cpu_addr[12:0]);

  p_last_fixed_r4: assert property (@(posedge clk) disable iff (rst)
    cpu_addr[14:13] == 2'b11 |-> prg_rom_addr[PRG_AW-1:13] == LAST);

  p_vram_low_r10: assert property (@(posedge clk) disable iff (rst)
    vram_addr[9:0] == vid_addr[9:0]);

  p_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(wr_en) && $stable(cpu_addr) && $stable(vid_addr))
      |-> ($stable(prg_rom_addr) && $stable(chr_addr) && $stable(vram_addr)));

  p_ignore_low_r9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wr_en) && !$past(wr_top) && $stable(cpu_addr) && $stable(vid_addr))
      |-> ($stable(prg_rom_addr) && $stable(chr_addr) && $stable(vram_addr)));

  if (CHR_BANKS == 0) begin : g_pass
    p_chr_pass_r8: assert property (@(posedge clk) disable iff (rst)
      chr_addr[12:0] == vid_addr);
  end else begin : g_map
    p_chr_pair_r6: assert property (@(posedge clk) disable iff (rst)
      vid_addr[12] == sel_q[7] |-> chr_addr[10] == vid_addr[10]);
  end
endmodule

bind cart_bank_xlat cbx_checker #(.PRG_BANKS(PRG_BANKS), .CHR_BANKS(CHR_BANKS)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .wr_en        (wr_en),
  .wr_top       (wr_addr[15]),
  .cpu_addr     (cpu_addr),
  .vid_addr     (vid_addr),
  .prg_rom_addr (prg_rom_addr),
  .chr_addr     (chr_addr),
  .vram_addr    (vram_addr),
  .sel_q        (sel_q)
);

// File: tb/tb_cart_bank_xlat.sv
module tb_cart_bank_xlat;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [14:0] cpu_addr = '0;
  logic [12:0] vid_addr = '0;
  logic [16:0] prg_rom_addr;
  logic [14:0] chr_addr;
  logic [10:0] vram_addr;
  logic [13:0] prg_ram_inst;
  logic [12:0] chr_pass;
  logic [10:0] vram_ram_inst;

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 0;

  always #2 clk = ~clk;

  cart_bank_xlat #(.PRG_BANKS(16), .CHR_BANKS(32)) dut (
    .clk, .rst, .wr_en, .wr_addr, .wr_data, .cpu_addr, .vid_addr,
    .prg_rom_addr (prg_rom_addr), .chr_addr (chr_addr), .vram_addr (vram_addr)
  );

  cart_bank_xlat #(.PRG_BANKS(4), .CHR_BANKS(0)) dut_ram (
    .clk, .rst, .wr_en, .wr_addr, .wr_data, .cpu_addr, .vid_addr,
    .prg_rom_addr (prg_ram_inst), .chr_addr (chr_pass), .vram_addr (vram_ram_inst)
  );

  // {req[3:0], kind[1:0], addr[15:0], value[16:0]}; kind 0 write, 1 prg, 2 chr, 3 vram
  localparam int NVEC = 53;
  localparam logic [38:0] VEC [NVEC] = '{
    {4'd2,  2'd0, 16'h8000, 17'h00006},  // R2 select=6
    {4'd2,  2'd0, 16'h8001, 17'h00035},  // R2 reg6=0x35
    {4'd2,  2'd0, 16'h8000, 17'h00007},
    {4'd2,  2'd0, 16'h8001, 17'h00009},  // reg7=9
    {4'd5,  2'd1, 16'h0010, 17'h0A010},  // R5 0x35 -> bank 5
    {4'd3,  2'd1, 16'h2010, 17'h12010},  // R3
    {4'd3,  2'd1, 16'h4010, 17'h1C010},  // R3
    {4'd3,  2'd1, 16'h7FFF, 17'h1FFFF},  // R3
    {4'd4,  2'd0, 16'h8000, 17'h00040},
    {4'd4,  2'd1, 16'h0010, 17'h1C010},  // R4
    {4'd4,  2'd1, 16'h4010, 17'h0A010},  // R4
    {4'd4,  2'd1, 16'h2010, 17'h12010},  // R4
    {4'd2,  2'd0, 16'h8001, 17'h0000B},  // reg0
    {4'd2,  2'd0, 16'h8000, 17'h00041},
    {4'd2,  2'd0, 16'h8001, 17'h00014},  // reg1
    {4'd2,  2'd0, 16'h8000, 17'h00042},
    {4'd2,  2'd0, 16'h8001, 17'h00003},  // reg2
    {4'd2,  2'd0, 16'h8000, 17'h00043},
    {4'd2,  2'd0, 16'h8001, 17'h00021},  // reg3
    {4'd2,  2'd0, 16'h8000, 17'h00044},
    {4'd2,  2'd0, 16'h8001, 17'h0001E},  // reg4
    {4'd2,  2'd0, 16'h8000, 17'h00045},
    {4'd2,  2'd0, 16'h8001, 17'h00007},  // reg5
    {4'd6,  2'd2, 16'h0000, 17'h02800},  // R6
    {4'd6,  2'd2, 16'h07FF, 17'h02FFF},  // R6
    {4'd6,  2'd2, 16'h0800, 17'h05000},  // R6
    {4'd6,  2'd2, 16'h0C01, 17'h05401},  // R6
    {4'd6,  2'd2, 16'h1000, 17'h00C00},  // R6
    {4'd5,  2'd2, 16'h1400, 17'h00400},  // R5 0x21 -> 1
    {4'd6,  2'd2, 16'h1800, 17'h07800},  // R6
    {4'd6,  2'd2, 16'h1C00, 17'h01C00},  // R6
    {4'd7,  2'd0, 16'h8000, 17'h00080},
    {4'd7,  2'd2, 16'h0000, 17'h00C00},  // R7
    {4'd7,  2'd2, 16'h0C00, 17'h01C00},  // R7
    {4'd7,  2'd2, 16'h1000, 17'h02800},  // R7
    {4'd7,  2'd2, 16'h1C00, 17'h05400},  // R7
    {4'd3,  2'd1, 16'h0000, 17'h0A000},  // R3
    {4'd10, 2'd3, 16'h0405, 17'h00405},  // R10
    {4'd9,  2'd0, 16'hA001, 17'h00001},  // R9 ignored
    {4'd9,  2'd3, 16'h0405, 17'h00405},  // R9
    {4'd9,  2'd0, 16'hC000, 17'h000FF},
    {4'd9,  2'd0, 16'hE001, 17'h00055},
    {4'd9,  2'd0, 16'h0000, 17'h000C0},
    {4'd9,  2'd1, 16'h0000, 17'h0A000},  // R9
    {4'd9,  2'd2, 16'h0000, 17'h00C00},  // R9
    {4'd9,  2'd0, 16'hA000, 17'h00001},
    {4'd10, 2'd3, 16'h0C05, 17'h00405},  // R10
    {4'd10, 2'd3, 16'h0405, 17'h00005},  // R10
    {4'd9,  2'd0, 16'hBFFE, 17'h00002},
    {4'd9,  2'd3, 16'h0405, 17'h00405},  // R9
    {4'd2,  2'd0, 16'h9FFE, 17'h00006},
    {4'd2,  2'd0, 16'h9FFF, 17'h00002},
    {4'd2,  2'd1, 16'h0000, 17'h04000}   // R2
  };

  task automatic check(input string tag, input logic [16:0] act, input logic [16:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic finish_run;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog R11 actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    cpu_addr = 15'h0123; #1 check("R1 window0", 17'(prg_rom_addr), 17'h00123);
    cpu_addr = 15'h4005; #1 check("R1 window2", 17'(prg_rom_addr), 17'h1C005);
    cpu_addr = 15'h6000; #1 check("R1 window3", 17'(prg_rom_addr), 17'h1E000);
    vid_addr = 13'h1400; #1 check("R1 chr", 17'(chr_addr), 17'h00000);
    vid_addr = 13'h0C05; #1 check("R1 mirror", 17'(vram_addr), 17'h00405);

    for (int i = 0; i < NVEC; i++) begin
      logic [3:0]  req;
      logic [1:0]  kind;
      logic [15:0] a;
      logic [16:0] v;
      {req, kind, a, v} = VEC[i];
      if (kind == 2'd0) begin
        do_write(a, v[7:0]);
      end else begin
        @(negedge clk);
        if (kind == 2'd1) begin
          cpu_addr = a[14:0]; #1 check($sformatf("R%0d vec%0d prg", req, i), 17'(prg_rom_addr), v);
        end else if (kind == 2'd2) begin
          vid_addr = a[12:0]; #1 check($sformatf("R%0d vec%0d chr", req, i), 17'(chr_addr), v);
        end else begin
          vid_addr = a[12:0]; #1 check($sformatf("R%0d vec%0d vram", req, i), 17'(vram_addr), v);
        end
      end
    end

    // R8 pass-through instance, after many bank writes
    vid_addr = 13'h1ABC; #1 check("R8 pass a", 17'(chr_pass), 17'h01ABC);
    vid_addr = 13'h0123; #1 check("R8 pass b", 17'(chr_pass), 17'h00123);

    // R11 write visible only after its edge (select=6, reg6=2)
    @(negedge clk);
    cpu_addr = 15'h0000;
    wr_en = 1'b1; wr_addr = 16'h8000; wr_data = 8'h40;
    #1 check("R11 before edge", 17'(prg_rom_addr), 17'h04000);
    @(posedge clk); #1 check("R11 after edge", 17'(prg_rom_addr), 17'h1C000);
    @(negedge clk);
    wr_en = 1'b0; wr_data = 8'h00;
    // R9 strobe low: select write must not happen
    repeat (2) @(negedge clk);
    #1 check("R9 wr_en low", 17'(prg_rom_addr), 17'h1C000);

    // R1 reset mid-run
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    cpu_addr = 15'h0000; #1 check("R1 rerun prg", 17'(prg_rom_addr), 17'h00000);
    vid_addr = 13'h0000; #1 check("R1 rerun chr", 17'(chr_addr), 17'h00000);
    vid_addr = 13'h0405; #1 check("R1 rerun vram", 17'(vram_addr), 17'h00405);

    done = 1;
    finish_run();
  end
endmodule